// File: doc/BRIEF.md
# Variable-Latency Integer Divider

This block divides a 32-bit dividend by a 16-bit divisor, either as unsigned numbers or as two's-complement numbers. It returns a 16-bit quotient, a 16-bit remainder and an overflow flag. Alongside the arithmetic result it reports the instruction time a processor would spend on that same division. The instruction time is counted in master-clock cycles, and it depends on the operand bits, so a cycle-accurate system model can charge the exact cost.

The latency is the CPU-cycle count multiplied by 14. That factor is seven master cycles per CPU cycle, doubled. When the reported latency reaches 896 master cycles (128 CPU cycles × 7), the block also raises a flag. The flag tells the bus-refresh scheduler to skip one refresh slot, because the instruction has covered a whole refresh period.

Internally, a restoring divider works on operand magnitudes and produces one quotient bit per clock. A cost accumulator follows each step. An FSM applies the signs, checks that the result fits, and registers the outputs.

Top module: `varlat_divider`

## Requirements
- R1: After reset, quotient_o, remainder_o, latency_o, overflow_o, skip_refresh_o and done_o are all zero.
- R2: Unsigned mode (signed_i=0) with dividend[31:16] < divisor: quotient_o = floor(dividend/divisor), remainder_o = dividend mod divisor, overflow_o=0.
- R3: Unsigned mode with dividend[31:16] >= divisor: overflow_o=1, quotient_o and remainder_o keep their previous values, latency_o = 140 (10 CPU cycles).
- R4: Unsigned mode without overflow: latency_o = 14 × (70 − number of one bits in the 16-bit quotient).
- R5: Signed mode (signed_i=1) without overflow: the quotient is truncated toward zero, and the remainder has the dividend's sign (or is zero).
- R6: Signed mode with |dividend|[31:16] >= |divisor|: overflow_o=1, quotient and remainder are unchanged, latency_o = 14 × (8 + 1 if the dividend is negative).
- R7: Signed mode when the R6 test passes: the CPU count is 61, plus 1 for a negative dividend. With a non-negative divisor, a non-negative dividend then takes 1 away and a negative dividend adds 1. Finally, 1 is added for each zero among bits 1..15 of |quotient|. latency_o is 14 times this count.
- R8: Signed mode when the R6 test passes but the signed quotient lies outside −32768..32767: overflow_o=1, quotient and remainder are unchanged, and latency_o still follows R7.
- R9: Whenever done_o is high, skip_refresh_o = (latency_o >= 896).
- R10: done_o is a one-cycle pulse. It rises on the 17th rising edge after the edge that samples start_i, or on the 1st such edge when the R3/R6 overflow test fires. The results hold between pulses.
- R11: A start_i pulse while a division is in progress is ignored. The running division completes with its own operands and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a division with the present operands |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 16 | Divisor |
| quotient_o | output | 16 | Quotient |
| remainder_o | output | 16 | Remainder |
| overflow_o | output | 1 | Quotient does not fit; results held |
| latency_o | output | 12 | Instruction time in master cycles |
| done_o | output | 1 | One-cycle result strobe |
| skip_refresh_o | output | 1 | Latency covers a refresh period |

## Verification
The unsigned operands are chosen to give quotients with very few or very many one bits, such as 10 and 0xFFFF. This separates the subtract-step discount from the shift cost and places the latency on either side of the refresh threshold. The signed operands cover all four sign combinations, a divisor of ±1, the most negative dividend, and quotients of exactly +32768 and −32768. These cases separate the early magnitude overflow from the late range overflow, and they check the sign-dependent latency adjustments. Random operands then compare quotient, remainder, latency and strobe timing against a behavioural model built from the requirements.

// File: rtl/varlat_div_pkg.sv
package varlat_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_OVF  = 2'd3
  } st_e;
endpackage

// File: rtl/varlat_div_core.sv
// Restoring magnitude divider: one quotient bit per enabled step.
module varlat_div_core #(
  parameter int QW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [2*QW-1:0] num_i,
  input  logic [QW-1:0]   den_i,
  output logic            take_o,
  output logic [QW-1:0]   quo_o,
  output logic [QW-1:0]   rem_o
);
  logic [QW-1:0] rem_q, rem_d;
  logic [QW-1:0] low_q, low_d;
  logic [QW-1:0] quo_q, quo_d;
  logic [QW-1:0] den_q, den_d;
  logic [QW:0]   trial;

  always_comb begin
    trial  = {rem_q, low_q[QW-1]};
    take_o = (trial >= {1'b0, den_q});
    rem_d  = rem_q;
    low_d  = low_q;
    quo_d  = quo_q;
    den_d  = den_q;
    if (load_i) begin
      rem_d = num_i[2*QW-1:QW];
      low_d = num_i[QW-1:0];
      quo_d = '0;
      den_d = den_i;
    end else if (step_i) begin
      rem_d = take_o ? (trial[QW-1:0] - den_q) : trial[QW-1:0];
      low_d = {low_q[QW-2:0], 1'b0};
      quo_d = {quo_q[QW-2:0], take_o};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      low_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (load_i || step_i) begin
      rem_q <= rem_d;
      low_q <= low_d;
      quo_q <= quo_d;
      den_q <= den_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/varlat_div_cost.sv
// CPU-cycle accumulator that tracks the divider step by step.
module varlat_div_cost #(
  parameter int CPU_W  = 8,
  parameter int U_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CPU_W-1:0] init_i,
  input  logic             step_i,
  input  logic             signed_i,
  input  logic             take_i,
  input  logic             last_i,
  output logic [CPU_W-1:0] cpu_o
);
  logic [CPU_W-1:0] cpu_q, cpu_d, inc;

  always_comb begin
    if (signed_i) begin
      // zero quotient bit above bit 0 costs one cycle
      inc = (!take_i && !last_i) ? CPU_W'(1) : '0;
    end else begin
      // every shift costs U_STEP, a subtracting step gives one back
      inc = take_i ? CPU_W'(U_STEP - 1) : CPU_W'(U_STEP);
    end
    cpu_d = cpu_q;
    if (load_i)      cpu_d = init_i;
    else if (step_i) cpu_d = cpu_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cpu_q <= '0;
    else if (load_i || step_i) cpu_q <= cpu_d;
  end

  assign cpu_o = cpu_q;
endmodule

// File: rtl/varlat_divider.sv
module varlat_divider
  import varlat_div_pkg::*;
#(
  parameter int QW          = 16,
  parameter int CPU_W       = 8,
  parameter int LAT_W       = 12,
  parameter int MCLK        = 7,
  parameter int REFRESH_CPU = 128,
  parameter int U_BASE      = 38,
  parameter int U_STEP      = 2,
  parameter int U_OVF       = 10,
  parameter int S_BASE      = 6,
  parameter int S_BODY      = 55,
  parameter int S_OVF       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [2*QW-1:0]  dividend_i,
  input  logic [QW-1:0]    divisor_i,
  output logic [QW-1:0]    quotient_o,
  output logic [QW-1:0]    remainder_o,
  output logic             overflow_o,
  output logic [LAT_W-1:0] latency_o,
  output logic             done_o,
  output logic             skip_refresh_o
);
  localparam int DW    = 2 * QW;
  localparam int CNT_W = $clog2(QW);
  localparam int THR   = REFRESH_CPU * MCLK;
  localparam logic [QW-1:0] MIN_MAG = {1'b1, {(QW-1){1'b0}}};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d, ndd_q, ndd_d, nq_q, nq_d;
  logic [QW-1:0]    quo_q, quo_d, rem_q, rem_d;
  logic             ovf_q, ovf_d, done_q, done_d, skip_q, skip_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             res_en, flag_en, ctl_en;

  logic             dd_neg, dv_neg, early_ovf;
  logic [DW-1:0]    dd_mag;
  logic [QW-1:0]    dv_mag;
  int               init_v;
  logic [CPU_W-1:0] init_cpu;

  logic             core_load, core_step, take, last_step, fits;
  logic [QW-1:0]    core_quo, core_rem;
  logic [CPU_W-1:0] cpu;
  logic [LAT_W-1:0] lat_calc;

  // operand magnitudes and the early overflow test
  always_comb begin
    dd_neg    = signed_i & dividend_i[DW-1];
    dv_neg    = signed_i & divisor_i[QW-1];
    dd_mag    = dd_neg ? (DW'(0) - dividend_i) : dividend_i;
    dv_mag    = dv_neg ? (QW'(0) - divisor_i) : divisor_i;
    early_ovf = (dd_mag[DW-1:QW] >= dv_mag);
    if (!signed_i) begin
      init_v = early_ovf ? U_OVF : U_BASE;
    end else begin
      init_v = S_BASE + (dd_neg ? 1 : 0);
      if (early_ovf) begin
        init_v = init_v + S_OVF;
      end else begin
        init_v = init_v + S_BODY;
        if (!dv_neg) init_v = init_v + (dd_neg ? 1 : -1);
      end
    end
    init_cpu = CPU_W'(init_v);
  end

  varlat_div_core #(.QW(QW)) u_core (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (core_load),
    .step_i (core_step),
    .num_i  (dd_mag),
    .den_i  (dv_mag),
    .take_o (take),
    .quo_o  (core_quo),
    .rem_o  (core_rem)
  );

  varlat_div_cost #(.CPU_W(CPU_W), .U_STEP(U_STEP)) u_cost (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_i   (core_load),
    .init_i   (init_cpu),
    .step_i   (core_step),
    .signed_i (mode_q),
    .take_i   (take),
    .last_i   (last_step),
    .cpu_o    (cpu)
  );

  assign last_step = (cnt_q == CNT_W'(QW - 1));
  assign lat_calc  = LAT_W'(cpu) * LAT_W'(2 * MCLK);

  // next-state process
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    mode_d    = mode_q;
    ndd_d     = ndd_q;
    nq_d      = nq_q;
    core_load = 1'b0;
    core_step = 1'b0;
    res_en    = 1'b0;
    flag_en   = 1'b0;
    ovf_d     = ovf_q;
    lat_d     = lat_q;
    skip_d    = skip_q;
    done_d    = 1'b0;
    fits      = !mode_q || (nq_q ? (core_quo <= MIN_MAG) : !core_quo[QW-1]);
    quo_d     = (mode_q && nq_q)  ? (QW'(0) - core_quo) : core_quo;
    rem_d     = (mode_q && ndd_q) ? (QW'(0) - core_rem) : core_rem;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          core_load = 1'b1;
          mode_d    = signed_i;
          ndd_d     = dd_neg;
          nq_d      = dd_neg ^ dv_neg;
          cnt_d     = '0;
          st_d      = early_ovf ? ST_OVF : ST_RUN;
        end
      end
      ST_RUN: begin
        core_step = 1'b1;
        cnt_d     = cnt_q + 1'b1;
        if (last_step) st_d = ST_FIN;
      end
      ST_FIN: begin
        flag_en = 1'b1;
        res_en  = fits;
        ovf_d   = !fits;
        lat_d   = lat_calc;
        skip_d  = (lat_calc >= LAT_W'(THR));
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_OVF: begin
        flag_en = 1'b1;
        ovf_d   = 1'b1;
        lat_d   = lat_calc;
        skip_d  = (lat_calc >= LAT_W'(THR));
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    ctl_en = (st_q != ST_IDLE) || start_i;
  end

  // register process
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      ndd_q  <= 1'b0;
      nq_q   <= 1'b0;
    end else if (ctl_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      ndd_q  <= ndd_d;
      nq_q   <= nq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (res_en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ovf_q  <= 1'b0;
      lat_q  <= '0;
      skip_q <= 1'b0;
    end else if (flag_en) begin
      ovf_q  <= ovf_d;
      lat_q  <= lat_d;
      skip_q <= skip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign quotient_o     = quo_q;
  assign remainder_o    = rem_q;
  assign overflow_o     = ovf_q;
  assign latency_o      = lat_q;
  assign skip_refresh_o = skip_q;
  assign done_o         = done_q;
endmodule

// File: rtl/varlat_divider_chk.sv
module varlat_divider_chk
  import varlat_div_pkg::*;
#(
  parameter int QW          = 16,
  parameter int LAT_W       = 12,
  parameter int MCLK        = 7,
  parameter int REFRESH_CPU = 128
) (
  input logic             clk,
  input logic             rst_n,
  input st_e              st_q,
  input logic [QW-1:0]    quotient_o,
  input logic [QW-1:0]    remainder_o,
  input logic             overflow_o,
  input logic [LAT_W-1:0] latency_o,
  input logic             done_o,
  input logic             skip_refresh_o
);
  localparam int THR = REFRESH_CPU * MCLK;

  // R10: the strobe lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: results only move together with the strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));

  // R3, R6, R8: an overflow leaves quotient and remainder untouched
  a_r3_ovf_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overflow_o) |-> ($stable(quotient_o) && $stable(remainder_o)));

  // R9: refresh skip agrees with the reported latency
  a_r9_skip: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (skip_refresh_o == (latency_o >= LAT_W'(THR))));

  // R7: latency is a whole, non-zero number of doubled CPU cycles
  a_r7_lat_granule: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((latency_o != '0) && ((latency_o % LAT_W'(2 * MCLK)) == '0)));

  // R11: a running division is not restarted
  a_r11_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> (st_q == ST_RUN || st_q == ST_FIN));

  // R10: the final state always delivers the strobe
  a_r10_fin_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN || st_q == ST_OVF) |=> done_o);
endmodule

bind varlat_divider varlat_divider_chk #(
  .QW(QW), .LAT_W(LAT_W), .MCLK(MCLK), .REFRESH_CPU(REFRESH_CPU)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .st_q           (st_q),
  .quotient_o     (quotient_o),
  .remainder_o    (remainder_o),
  .overflow_o     (overflow_o),
  .latency_o      (latency_o),
  .done_o         (done_o),
  .skip_refresh_o (skip_refresh_o)
);

// File: tb/varlat_divider_tb_top.sv
`timescale 1ns/1ps
module varlat_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        smode = 1'b0;
  logic [31:0] dd = '0;
  logic [15:0] dv = '0;
  logic [15:0] q, r;
  logic        ovf, done, skip;
  logic [11:0] lat;

  int checks = 0;
  int errors = 0;
  logic [15:0] prev_q = '0;
  logic [15:0] prev_r = '0;

  always #5 clk = ~clk;

  varlat_divider dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(smode),
    .dividend_i(dd), .divisor_i(dv), .quotient_o(q), .remainder_o(r),
    .overflow_o(ovf), .latency_o(lat), .done_o(done), .skip_refresh_o(skip)
  );

  // stimulus table: {signed, dividend, divisor}
  localparam logic [48:0] VEC [16] = '{
    {1'b0, 32'd100,        16'd10},
    {1'b0, 32'h0000_FFFF,  16'h0001},
    {1'b0, 32'h1234_5678,  16'h4321},
    {1'b0, 32'hFFFF_FFFF,  16'hFFFF},
    {1'b0, 32'hFFFE_FFFF,  16'hFFFF},
    {1'b0, 32'h0001_0000,  16'h0001},
    {1'b1, 32'd7,          16'hFFFE},
    {1'b1, 32'hFFFF_FFF9,  16'h0002},
    {1'b1, 32'h0000_8000,  16'h0001},
    {1'b1, 32'hFFFF_8000,  16'h0001},
    {1'b1, 32'h8000_0000,  16'hFFFF},
    {1'b1, 32'h8000_0000,  16'h8000},
    {1'b1, 32'hFFFF_FF9C,  16'hFFF9},
    {1'b1, 32'h3FFF_8000,  16'h7FFF},
    {1'b1, 32'd1,          16'hFFFF},
    {1'b1, 32'd0,          16'd5}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference built from the requirements
  task automatic model(input logic sm, input logic [31:0] a, input logic [15:0] b,
                       output logic [15:0] eq, output logic [15:0] er, output logic eo,
                       output int elat, output logic esk, output int eclk);
    longint sa, sb, ma, mb, qm, rm, qs, tmp;
    int cpu;
    eq = prev_q; er = prev_r; eo = 1'b0;
    if (!sm) begin
      if (a[31:16] >= b) begin
        eo = 1'b1; cpu = 10; eclk = 2;
      end else begin
        qm = longint'(a) / longint'(b);
        rm = longint'(a) % longint'(b);
        eq = qm[15:0]; er = rm[15:0];
        cpu = 70 - $countones(qm[15:0]);
        eclk = 18;
      end
    end else begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      ma = (sa < 0) ? -sa : sa;
      mb = (sb < 0) ? -sb : sb;
      cpu = 6 + ((sa < 0) ? 1 : 0);
      if ((ma >> 16) >= mb) begin
        eo = 1'b1; cpu += 2; eclk = 2;
      end else begin
        eclk = 18;
        cpu += 55;
        if (sb >= 0) cpu += (sa >= 0) ? -1 : 1;
        qm = ma / mb;
        rm = ma % mb;
        for (int i = 1; i < 16; i++) if (qm[i] == 1'b0) cpu++;
        qs = ((sa < 0) != (sb < 0)) ? -qm : qm;
        if (qs > 32767 || qs < -32768) begin
          eo = 1'b1;
        end else begin
          eq = qs[15:0];
          tmp = (sa < 0) ? -rm : rm;
          er = tmp[15:0];
        end
      end
    end
    elat = cpu * 14;
    esk  = (elat >= 896);
  endtask

  task automatic run(input logic sm, input logic [31:0] a, input logic [15:0] b, input string req);
    logic [15:0] eq, er;
    logic eo, esk;
    int elat, eclk, n;
    model(sm, a, b, eq, er, eo, elat, esk, eclk);
    @(negedge clk);
    smode = sm; dd = a; dv = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(req, "R10 done strobe seen", longint'(done), 1);
    chk(req, "R10 strobe cycle", n, eclk);
    chk(req, "quotient", longint'(q), longint'(eq));
    chk(req, "remainder", longint'(r), longint'(er));
    chk(req, "overflow", longint'(ovf), longint'(eo));
    chk(req, "latency", longint'(lat), elat);
    chk(req, "R9 skip", longint'(skip), longint'(esk));
    if (!eo) begin prev_q = eq; prev_r = er; end
    @(negedge clk);
    chk(req, "R10 strobe single", longint'(done), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "quotient", longint'(q), 0);
    chk("R1", "remainder", longint'(r), 0);
    chk("R1", "latency", longint'(lat), 0);
    chk("R1", "overflow", longint'(ovf), 0);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "skip", longint'(skip), 0);

    // table walk (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 16; k++) begin
      run(VEC[k][48], VEC[k][47:16], VEC[k][15:0], VEC[k][48] ? "R5/R6/R7/R8" : "R2/R3/R4");
    end

    // directed values worked by hand
    run(1'b0, 32'd100, 16'd10, "R4");
    chk("R4", "100/10 latency", longint'(lat), 952);
    chk("R9", "100/10 skip", longint'(skip), 1);
    run(1'b0, 32'h0000_FFFF, 16'd1, "R4");
    chk("R4", "ffff/1 latency", longint'(lat), 756);
    chk("R9", "ffff/1 no skip", longint'(skip), 0);
    run(1'b1, 32'hFFFF_FFF9, 16'h0002, "R5");
    chk("R5", "-7/2 quotient", longint'(q), 16'hFFFD);
    chk("R5", "-7/2 remainder", longint'(r), 16'hFFFF);
    chk("R7", "-7/2 latency", longint'(lat), 1078);
    run(1'b1, 32'h8000_0000, 16'hFFFF, "R6");
    chk("R6", "min/-1 overflow", longint'(ovf), 1);
    chk("R6", "min/-1 latency", longint'(lat), 126);
    chk("R6", "min/-1 quotient held", longint'(q), 16'hFFFD);
    run(1'b1, 32'h0000_8000, 16'h0001, "R8");
    chk("R8", "32768/1 overflow", longint'(ovf), 1);
    chk("R8", "32768/1 latency", longint'(lat), 1036);
    run(1'b0, 32'hFFFF_FFFF, 16'hFFFF, "R3");
    chk("R3", "latency", longint'(lat), 140);

    // R11: second start during a division is ignored
    begin
      logic [15:0] eq, er;
      logic eo, esk;
      int elat, eclk, n;
      model(1'b0, 32'd100, 16'd10, eq, er, eo, elat, esk, eclk);
      @(negedge clk);
      smode = 1'b0; dd = 32'd100; dv = 16'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      repeat (3) begin @(negedge clk); n++; end
      smode = 1'b0; dd = 32'hFFFF_FFFF; dv = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
      while (!done && n < 100) begin @(negedge clk); n++; end
      chk("R11", "strobe cycle", n, eclk);
      chk("R11", "quotient", longint'(q), longint'(eq));
      chk("R11", "overflow", longint'(ovf), 0);
      chk("R11", "latency", longint'(lat), elat);
      prev_q = eq; prev_r = er;
      repeat (20) @(negedge clk);
      chk("R11", "no late strobe", longint'(done), 0);
    end

    // random operands
    for (int k = 0; k < 40; k++) begin
      logic        rs;
      logic [31:0] ra;
      logic [15:0] rb;
      rs = 1'($urandom % 2);
      ra = $urandom;
      rb = 16'($urandom);
      if (k % 2 == 0) ra = ra >> ($urandom % 17);
      run(rs, ra, rb, rs ? "R5/R7 random" : "R2/R4 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule